// File: doc/BRIEF.md
# Page-Table Entry Change Classifier

This block watches stores that land in guest page-table pages placed under write protection. For every such store it receives the entry value before the write, the value after it, and a tag naming the table level. It works out whether the store alters a translation that protection depends on. It then reports one event to downstream logic, which adds or removes protection on the frames it names.

The decision rests on two things: how the present flag changes, and whether the physical frame field differs. A page coming into memory is reported with its new frame. A page leaving memory is reported with its old frame. A page moving to another frame is reported with both frames. Stores that only touch the accessed or dirty flags or other control bits produce an ignore event. Stores to an entry that is absent both before and after also produce an ignore event.

Every accepted input produces exactly one registered result. The result is held until downstream takes it, and while it is held the input is stalled.

Top module: `pte_change_classifier`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Old bit 0 = 0 and new bit 0 = 1 gives event code 1 (swap-in). `out_new_frame` carries new bits 51:12 and `out_old_frame` is 0.
- R3: Old bit 0 = 1 and new bit 0 = 0 gives event code 2 (swap-out). `out_old_frame` carries old bits 51:12 and `out_new_frame` is 0.
- R4: Both bit 0 = 1 with differing bits 51:12 gives event code 3 (remap), with both frames reported.
- R5: Both bit 0 = 1 with equal bits 51:12 gives event code 0 (ignore) and both frame outputs 0, even when bit 5 (accessed), bit 6 (dirty) or other flag bits differ.
- R6: Both bit 0 = 0 gives event code 0 with both frame outputs 0, whatever the other bits hold.
- R7: Only bits 51:12 form the frame. Differences confined to bits 63:52 or 11:1 never give remap.
- R8: A transfer accepted at a clock edge (`in_valid` and `in_ready` high) appears at the next edge with `out_valid` = 1 and the level tag copied to `out_level`.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and all outputs hold their values.
- R10: With `out_ready` held at 1, one input is accepted every cycle, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Write descriptor present |
| in_ready | output | 1 | Block can take a descriptor |
| in_old | input | 64 | Entry value before the store |
| in_new | input | 64 | Entry value after the store |
| in_level | input | 2 | Table level tag, passed through |
| out_valid | output | 1 | Result held on outputs |
| out_ready | input | 1 | Downstream takes the result |
| out_evt | output | 2 | 0 ignore, 1 swap-in, 2 swap-out, 3 remap |
| out_old_frame | output | 40 | Reported old frame number |
| out_new_frame | output | 40 | Reported new frame number |
| out_level | output | 2 | Level tag of the result |

## Verification
The bench builds the block at its defaults: 64-bit entries, the present flag at bit 0 and the frame at bits 51:12. With those values, stimulus that flips only bits above 51, only the low flag bits, or only accessed and dirty can be told apart from a real frame change. Random pairs are drawn from flag-only flips, present flips, frame changes and unrelated values, so that all four event codes occur often. Stall and back-to-back sequences cover the handshake.

// File: rtl/pte_cls_pkg.sv
// Shared event encoding for the page-table entry change classifier.
package pte_cls_pkg;
    typedef enum logic [1:0] {
        EVT_IGNORE   = 2'd0,
        EVT_SWAP_IN  = 2'd1,
        EVT_SWAP_OUT = 2'd2,
        EVT_REMAP    = 2'd3
    } pte_evt_e;
endpackage

// File: rtl/pte_field_extract.sv
// Pulls the present flag and the frame number out of one entry.
// Assumes PRESENT_BIT and FRAME_LO..FRAME_HI lie inside ENTRY_W.
module pte_field_extract #(
    parameter int ENTRY_W     = 64,
    parameter int PRESENT_BIT = 0,
    parameter int FRAME_LO    = 12,
    parameter int FRAME_HI    = 51,
    localparam int FRAME_W    = FRAME_HI - FRAME_LO + 1
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    // Other flag bits do not enter the decision on purpose.
    logic unused_bits;
    assign unused_bits = ^entry;

    // Field selection.
    always_comb begin
        present = entry[PRESENT_BIT];
        frame   = entry[FRAME_HI:FRAME_LO];
    end
endmodule

// File: rtl/pte_event_decode.sv
// Classifies one store from the present flags and frames of both values.
// It reports only the frames that the chosen event needs and zeroes the rest.
module pte_event_decode
    import pte_cls_pkg::*;
#(
    parameter int FRAME_W = 40
) (
    input  logic               old_present,
    input  logic               new_present,
    input  logic [FRAME_W-1:0] old_frame,
    input  logic [FRAME_W-1:0] new_frame,
    output pte_evt_e           evt,
    output logic [FRAME_W-1:0] rep_old_frame,
    output logic [FRAME_W-1:0] rep_new_frame
);
    // Present-flag transition plus frame compare selects the event.
    always_comb begin
        evt           = EVT_IGNORE;
        rep_old_frame = '0;
        rep_new_frame = '0;
        unique case ({old_present, new_present})
            2'b01: begin
                evt           = EVT_SWAP_IN;
                rep_new_frame = new_frame;
            end
            2'b10: begin
                evt           = EVT_SWAP_OUT;
                rep_old_frame = old_frame;
            end
            2'b11: begin
                if (old_frame != new_frame) begin
                    evt           = EVT_REMAP;
                    rep_old_frame = old_frame;
                    rep_new_frame = new_frame;
                end
            end
            default: evt = EVT_IGNORE;
        endcase
    end
endmodule

// File: rtl/pte_out_stage.sv
// Single result register with valid/ready. While a result is held and not
// taken, it stalls the producer. It assumes the producer keeps its data
// steady while it is stalled.
module pte_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic load;

    // Accept when empty or when the held result leaves this cycle.
    assign in_ready = !out_valid || out_ready;
    assign load     = in_valid && in_ready;

    // Valid flag: set on load, cleared when taken with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (load)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Payload register: captured only on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (load) out_data <= in_data;
    end
endmodule

// File: rtl/pte_change_classifier.sv
// Top level: splits old and new entries into fields, classifies the store
// and registers the event with frames and level tag. It assumes the
// entries come from long-mode tables that map 4 KiB pages.
module pte_change_classifier
    import pte_cls_pkg::*;
#(
    parameter int ENTRY_W     = 64,
    parameter int PRESENT_BIT = 0,
    parameter int FRAME_LO    = 12,
    parameter int FRAME_HI    = 51,
    parameter int LEVEL_W     = 2,
    localparam int FRAME_W    = FRAME_HI - FRAME_LO + 1,
    localparam int PAY_W      = 2 + 2 * FRAME_W + LEVEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ENTRY_W-1:0] in_old,
    input  logic [ENTRY_W-1:0] in_new,
    input  logic [LEVEL_W-1:0] in_level,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_evt,
    output logic [FRAME_W-1:0] out_old_frame,
    output logic [FRAME_W-1:0] out_new_frame,
    output logic [LEVEL_W-1:0] out_level
);
    logic [ENTRY_W-1:0] entries  [2];
    logic               presents [2];
    logic [FRAME_W-1:0] frames   [2];
    pte_evt_e           evt;
    logic [FRAME_W-1:0] rep_old, rep_new;
    logic [PAY_W-1:0]   pay_in, pay_out;

    assign entries[0] = in_old;
    assign entries[1] = in_new;

    // One field extractor per entry value (0 = old, 1 = new).
    for (genvar i = 0; i < 2; i++) begin : g_ext
        pte_field_extract #(
            .ENTRY_W(ENTRY_W), .PRESENT_BIT(PRESENT_BIT),
            .FRAME_LO(FRAME_LO), .FRAME_HI(FRAME_HI)
        ) u_ext (
            .entry(entries[i]), .present(presents[i]), .frame(frames[i])
        );
    end

    pte_event_decode #(.FRAME_W(FRAME_W)) u_dec (
        .old_present(presents[0]), .new_present(presents[1]),
        .old_frame(frames[0]), .new_frame(frames[1]),
        .evt(evt), .rep_old_frame(rep_old), .rep_new_frame(rep_new)
    );

    // Pack the result for the output register.
    assign pay_in = {evt, rep_old, rep_new, in_level};

    pte_out_stage #(.DATA_W(PAY_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
    );

    // Unpack the registered result onto the ports.
    assign {out_evt, out_old_frame, out_new_frame, out_level} = pay_out;
endmodule

// File: rtl/pte_cls_checker.sv
// Protocol and classification properties for the classifier, bound to the top.
module pte_cls_checker #(
    parameter int ENTRY_W = 64,
    parameter int FRAME_W = 40,
    parameter int LEVEL_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [ENTRY_W-1:0] in_old,
    input logic [ENTRY_W-1:0] in_new,
    input logic [LEVEL_W-1:0] in_level,
    input logic               out_valid,
    input logic               out_ready,
    input logic [1:0]         out_evt,
    input logic [FRAME_W-1:0] out_old_frame,
    input logic [FRAME_W-1:0] out_new_frame,
    input logic [LEVEL_W-1:0] out_level
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
    // R2
    swap_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_old[0] && in_new[0]) |=> (out_evt == 2'd1 && out_old_frame == '0));
    // R3
    swap_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_old[0] && !in_new[0]) |=> (out_evt == 2'd2 && out_new_frame == '0));
    // R4
    remap_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_evt == 2'd3) |-> (out_old_frame != out_new_frame));
    // R6
    absent_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_old[0] && !in_new[0]) |=> (out_evt == 2'd0 && out_old_frame == '0 && out_new_frame == '0));
    // R8
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_level == $past(in_level)));
    // R9
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_evt) && $stable(out_old_frame)
                                       && $stable(out_new_frame) && $stable(out_level)));
endmodule

bind pte_change_classifier pte_cls_checker #(
    .ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W), .LEVEL_W(LEVEL_W)
) u_pte_cls_chk (.*);

// File: tb/tb_pte_change_classifier.sv
`timescale 1ns/1ps
module tb_pte_change_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_old = '0;
    logic [63:0] in_new = '0;
    logic [1:0]  in_level = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_evt;
    logic [39:0] out_old_frame, out_new_frame;
    logic [1:0]  out_level;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pte_change_classifier dut (.*);

    // Expected event code from the requirements.
    function automatic logic [1:0] ref_evt(logic [63:0] o, logic [63:0] n);
        if (!o[0] && n[0]) return 2'd1;
        if (o[0] && !n[0]) return 2'd2;
        if (o[0] && n[0] && (o[51:12] != n[51:12])) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [39:0] ref_old(logic [63:0] o, logic [63:0] n);
        logic [1:0] e = ref_evt(o, n);
        return (e == 2'd2 || e == 2'd3) ? o[51:12] : 40'd0;
    endfunction

    function automatic logic [39:0] ref_new(logic [63:0] o, logic [63:0] n);
        logic [1:0] e = ref_evt(o, n);
        return (e == 2'd1 || e == 2'd3) ? n[51:12] : 40'd0;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [63:0] o, logic [63:0] n, logic [1:0] lv);
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " evt"}, 64'(out_evt), 64'(ref_evt(o, n)));
        chk({req, " old"}, 64'(out_old_frame), 64'(ref_old(o, n)));
        chk({req, " new"}, 64'(out_new_frame), 64'(ref_new(o, n)));
        chk({req, " level R8"}, 64'(out_level), 64'(lv));
    endtask

    // Present one descriptor, check it is taken, then check the result.
    task automatic send(string req, logic [63:0] o, logic [63:0] n, logic [1:0] lv);
        @(negedge clk);
        in_valid = 1'b1; in_old = o; in_new = n; in_level = lv; out_ready = 1'b1;
        chk({req, " ready R10"}, 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk_out(req, o, n, lv);
    endtask

    initial begin
        logic [63:0] a, b, c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'(out_valid), 64'd0);

        a = 64'h8000_0ABC_DEF1_2063;
        send("R2 swap-in", a & ~64'd1, a, 2'd3);
        send("R3 swap-out", a, a & ~64'd1, 2'd1);
        send("R4 remap", a, a ^ 64'h0000_0010_0000_0000, 2'd2);
        send("R4 remap low frame bit", a, a ^ 64'h1000, 2'd0);
        send("R5 accessed/dirty flip", a, a ^ 64'h60, 2'd0);
        send("R5 flag bits flip", a, a ^ 64'h0000_0000_0000_0F9E, 2'd1);
        send("R6 both absent", 64'h0000_1234_5678_9000, 64'hFFFF_EDCB_A987_6FFE, 2'd2);
        send("R7 high bits only", a, a ^ 64'hFFF0_0000_0000_0000, 2'd3);

        // R10: back to back, one accept per cycle.
        b = 64'h0000_0001_0000_1001;
        c = 64'h0000_0002_0000_2001;
        @(negedge clk);
        in_valid = 1'b1; in_old = b; in_new = c; in_level = 2'd1; out_ready = 1'b1;
        @(negedge clk);
        chk("R10 first ready", 64'(in_ready), 64'd1);
        chk_out("R10 first", b, c, 2'd1);
        in_old = c; in_new = c & ~64'd1; in_level = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;
        chk_out("R10 second", c, c & ~64'd1, 2'd2);

        // R9: stall holds result and blocks input.
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_old = b & ~64'd1; in_new = b; in_level = 2'd3;
        @(negedge clk);
        chk_out("R9 held A", b & ~64'd1, b, 2'd3);
        in_old = b; in_new = c; in_level = 2'd0;
        chk("R9 ready low", 64'(in_ready), 64'd0);
        repeat (2) @(negedge clk);
        chk_out("R9 still A", b & ~64'd1, b, 2'd3);
        chk("R9 ready still low", 64'(in_ready), 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk_out("R9 B after release", b, c, 2'd0);
        @(negedge clk);
        chk("R9 drained", 64'(out_valid), 64'd0);

        // Random mix covering all event codes.
        for (int i = 0; i < 400; i++) begin
            logic [63:0] o, n;
            o = {$urandom, $urandom};
            case ($urandom % 5)
                0: n = {$urandom, $urandom};
                1: n = o ^ (64'($urandom % 4) << 5);
                2: n = o ^ 64'd1;
                3: n = o ^ (64'($urandom) << 12) ^ 64'(o[0] ? 0 : 1);
                default: n = o ^ {12'($urandom), 40'd0, 12'($urandom & 32'hFFE)};
            endcase
            send("R2-mix random", o, n, 2'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule